// File: doc/BRIEF.md
# Receive FIFO with Hysteretic RTS Flow Control

This block is the receive-side buffer of a serial port. Each character that leaves the receive shift register is written together with its three error tags (parity, framing, break) into a 64-deep queue, and the host pops characters in arrival order. The head entry is always visible on the read outputs, so a read strobe consumes the character already shown.

The buffer also paces the remote transmitter through an active-low request-to-send output. A 2-bit select chooses one of four receive trigger levels. Reaching the selected level raises the data-ready interrupt. RTS is not withdrawn at that level. It goes high only at the next level up in the trigger table, and it comes back low only once the buffer drains to the next level down. This gap keeps the line from toggling on every character. After RTS goes high the buffer keeps accepting characters until it is completely full. An optional interrupt flags each rising edge of the RTS output.

Top module: `rx_rts_fifo`

## Requirements
- R1: Characters are read in the order they were accepted. Each one appears on `rd_data` together with the 3-bit `rd_err` tag that was written with it. The head entry is shown before `rd_en` consumes it.
- R2: `count` rises by one for each accepted write and falls by one for each read while the buffer is non-empty. A read and a write in the same cycle on a non-empty buffer leave `count` unchanged. `count` never exceeds 64.
- R3: A write while `count` is 64 and no read happens in the same cycle is dropped. It sets the sticky `overrun` flag, which only `ovr_clr` clears.
- R4: `rx_irq` is high exactly while `count` is at or above the selected trigger level. The levels are 8, 16, 56 and 60 for `trig_sel` values 0, 1, 2 and 3.
- R5: With automatic RTS active, `rts_n` goes high in the cycle the updated count reaches the off level. The off levels are 16, 56, 60 and 60 for `trig_sel` 0, 1, 2 and 3. Reaching the trigger level alone leaves `rts_n` low.
- R6: Once high under automatic control, `rts_n` returns low only when the updated count falls to the on level. The on levels are 0, 8, 16 and 56 for `trig_sel` 0, 1, 2 and 3.
- R7: With `auto_rts_en` low, `rts_n` is the inverse of `rts_start`, registered one cycle.
- R8: With `auto_rts_en` high, `rts_n` is held high while `rts_start` is low. Setting `rts_start` starts automatic control from the RTS-on state (`rts_n` low).
- R9: When `rts_irq_en` is high, a low-to-high transition of `rts_n` sets `rts_irq` in the same cycle. `rts_irq_ack` clears it. With `rts_irq_en` low, no transition sets it.
- R10: After reset the buffer is empty, `rts_n` is high, and `rx_irq`, `rts_irq` and `overrun` are low.
- R11: A read while the buffer is empty has no effect on `count` or the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receive shift register |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error tags of the received character |
| rd_en | input | 1 | Host read strobe, pops the head entry |
| rd_data | output | 8 | Head character |
| rd_err | output | 3 | Error tags of the head character |
| trig_sel | input | 2 | Receive trigger level select |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| rts_start | input | 1 | RTS start; drives RTS low directly when automatic control is off |
| rts_irq_en | input | 1 | Enables the RTS-rise interrupt |
| rts_irq_ack | input | 1 | Clears the RTS interrupt status |
| ovr_clr | input | 1 | Clears the overrun flag |
| count | output | 7 | Number of stored characters |
| rx_irq | output | 1 | Data-ready interrupt |
| rts_irq | output | 1 | RTS-rise interrupt status |
| overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Active-low request to send |

## Verification
The checker watches several properties on every cycle. The count bound and the steady count under a joint read and write are checked this way. So are the conditions that allow `overrun` to rise, and the registered mirror of `rts_start` when automatic control is off. Each edge of `rts_n` under automatic control is checked against the off or on level of the selected trigger, and every rise of `rts_irq` must coincide with a rise of `rts_n`. Other behaviours need a scenario in the bench. These are the in-order delivery of data and error tags, the exact threshold crossings for different trigger selections, the dropped write at full, and a read from empty that changes nothing.

// File: rtl/rx_rts_pkg.sv
package rx_rts_pkg;

    // Receive trigger table, indexed by trigger select.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 56;
            default: return 60;
        endcase
    endfunction

    // RTS withdrawn at the next table entry above the trigger.
    function automatic int unsigned off_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 56;
            default: return 60;
        endcase
    endfunction

    // RTS reasserted at the next table entry below the trigger.
    function automatic int unsigned on_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 56;
        endcase
    endfunction

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 11,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_d,
    output logic              drop
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_q, s_d;
    logic [WORD_W-1:0] mem [DEPTH];
    logic push, pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d  = s_q;
        pop  = rd_en && (s_q.cnt != '0);
        push = wr_en && ((s_q.cnt != CNT_W'(DEPTH)) || pop);
        drop = wr_en && !push;
        if (push) s_d.wp = bump(s_q.wp);
        if (pop)  s_d.rp = bump(s_q.rp);
        if (push && !pop)      s_d.cnt = s_q.cnt + 1'b1;
        else if (pop && !push) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[s_q.wp] <= wr_word;
    end

    assign rd_word = mem[s_q.rp];
    assign cnt_q   = s_q.cnt;
    assign cnt_d   = s_d.cnt;

endmodule

// File: rtl/rx_rts_ctrl.sv
module rx_rts_ctrl
    import rx_rts_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             drop,
    input  logic [1:0]       trig_sel,
    input  logic             auto_en,
    input  logic             start,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             ovr_clr,
    output logic             rts_n,
    output logic             rts_irq,
    output logic             overrun,
    output logic             rx_irq
);

    typedef struct packed {
        logic off;
        logic armed;
        logic irq;
        logic ovr;
    } st_t;

    st_t s_q, s_d;
    logic [CNT_W-1:0] off_thr, on_thr;

    always_comb begin
        s_d     = s_q;
        off_thr = CNT_W'(off_level(trig_sel));
        on_thr  = CNT_W'(on_level(trig_sel));
        s_d.armed = auto_en && start;
        if (!auto_en)       s_d.off = !start;
        else if (!start)    s_d.off = 1'b1;
        else if (!s_q.armed) s_d.off = 1'b0;
        else if (s_q.off)   s_d.off = !(cnt_d <= on_thr);
        else                s_d.off = (cnt_d >= off_thr);
        if (irq_en && s_d.off && !s_q.off) s_d.irq = 1'b1;
        else if (irq_ack)                  s_d.irq = 1'b0;
        if (drop)         s_d.ovr = 1'b1;
        else if (ovr_clr) s_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{off: 1'b1, armed: 1'b0, irq: 1'b0, ovr: 1'b0};
        else        s_q <= s_d;
    end

    assign rts_n   = s_q.off;
    assign rts_irq = s_q.irq;
    assign overrun = s_q.ovr;
    assign rx_irq  = (cnt_q >= CNT_W'(trig_level(trig_sel)));

endmodule

// File: rtl/rx_rts_fifo.sv
module rx_rts_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int ERR_W  = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int WORD_W = DATA_W + ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  rd_err,
    input  logic [1:0]        trig_sel,
    input  logic              auto_rts_en,
    input  logic              rts_start,
    input  logic              rts_irq_en,
    input  logic              rts_irq_ack,
    input  logic              ovr_clr,
    output logic [CNT_W-1:0]  count,
    output logic              rx_irq,
    output logic              rts_irq,
    output logic              overrun,
    output logic              rts_n
);

    logic [WORD_W-1:0] head_word;
    logic [CNT_W-1:0]  cnt_next;
    logic              wr_drop;

    rx_fifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word ({wr_err, wr_data}),
        .rd_en   (rd_en),
        .rd_word (head_word),
        .cnt_q   (count),
        .cnt_d   (cnt_next),
        .drop    (wr_drop)
    );

    rx_rts_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (count),
        .cnt_d    (cnt_next),
        .drop     (wr_drop),
        .trig_sel (trig_sel),
        .auto_en  (auto_rts_en),
        .start    (rts_start),
        .irq_en   (rts_irq_en),
        .irq_ack  (rts_irq_ack),
        .ovr_clr  (ovr_clr),
        .rts_n    (rts_n),
        .rts_irq  (rts_irq),
        .overrun  (overrun),
        .rx_irq   (rx_irq)
    );

    assign rd_data = head_word[DATA_W-1:0];
    assign rd_err  = head_word[WORD_W-1:DATA_W];

endmodule

// File: rtl/rx_rts_fifo_chk.sv
module rx_rts_fifo_chk
    import rx_rts_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int ERR_W  = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [ERR_W-1:0]  wr_err,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [ERR_W-1:0]  rd_err,
    input logic [1:0]        trig_sel,
    input logic              auto_rts_en,
    input logic              rts_start,
    input logic              rts_irq_en,
    input logic              rts_irq_ack,
    input logic              ovr_clr,
    input logic [CNT_W-1:0]  count,
    input logic              rx_irq,
    input logic              rts_irq,
    input logic              overrun,
    input logic              rts_n
);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_rw_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(wr_en) && $past(count) != '0) |-> $stable(count));

    assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(overrun)) |->
            ($past(wr_en) && !$past(rd_en) && $past(count) == CNT_W'(DEPTH)));

    assert_rts_off_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(rts_n) && $past(auto_rts_en) && $past(rts_start)) |->
            (count >= CNT_W'(off_level($past(trig_sel)))));

    assert_rts_on_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $fell(rts_n) && $past(auto_rts_en) && $past(rts_start)
         && $past(auto_rts_en, 2) && $past(rts_start, 2)) |->
            (count <= CNT_W'(on_level($past(trig_sel)))));

    assert_manual_rts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(auto_rts_en)) |-> (rts_n == !$past(rts_start)));

    assert_irq_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(rts_irq)) |-> ($rose(rts_n) && $past(rts_irq_en)));

endmodule

bind rx_rts_fifo rx_rts_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/rx_rts_fifo_tb.sv
module rx_rts_fifo_tb;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, rd_en;
    logic [7:0] wr_data, rd_data;
    logic [2:0] wr_err, rd_err;
    logic [1:0] trig_sel;
    logic       auto_rts_en, rts_start, rts_irq_en, rts_irq_ack, ovr_clr;
    logic [6:0] count;
    logic       rx_irq, rts_irq, overrun, rts_n;

    int checks = 0;
    int fails  = 0;
    int mcnt   = 0;
    int seq    = 0;
    bit done   = 0;
    logic [10:0] sbq[$];

    always #10 clk = ~clk;

    rx_rts_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .trig_sel(trig_sel),
        .auto_rts_en(auto_rts_en), .rts_start(rts_start), .rts_irq_en(rts_irq_en),
        .rts_irq_ack(rts_irq_ack), .ovr_clr(ovr_clr), .count(count), .rx_irq(rx_irq),
        .rts_irq(rts_irq), .overrun(overrun), .rts_n(rts_n)
    );

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic post_checks();
        chk(count == 7'(mcnt), "R2 count", int'(count), mcnt);
        chk(rx_irq == (mcnt >= trig_of(trig_sel)), "R4 rx_irq", int'(rx_irq), int'(mcnt >= trig_of(trig_sel)));
    endtask

    // Driver: write one character, pushing the expected entry when it will be accepted.
    task automatic wr1();
        wr_en   = 1'b1;
        wr_data = 8'(seq * 37 + 5);
        wr_err  = 3'(seq % 7);
        if (mcnt < DEPTH) begin
            sbq.push_back({wr_err, wr_data});
            mcnt++;
        end
        seq++;
        step();
        wr_en = 1'b0;
        post_checks();
    endtask

    task automatic rd1();
        rd_en = 1'b1;
        if (mcnt > 0) mcnt--;
        step();
        rd_en = 1'b0;
        post_checks();
    endtask

    task automatic rw1();
        wr_en   = 1'b1;
        rd_en   = 1'b1;
        wr_data = 8'(seq * 37 + 5);
        wr_err  = 3'(seq % 7);
        sbq.push_back({wr_err, wr_data});
        seq++;
        step();
        wr_en = 1'b0;
        rd_en = 1'b0;
        post_checks();
    endtask

    task automatic fill_to(input int n);
        while (mcnt < n) wr1();
    endtask

    task automatic drain_to(input int n);
        while (mcnt > n) rd1();
    endtask

    // Monitor: just before each edge, compare the head entry being consumed.
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (rst_n === 1'b1 && rd_en === 1'b1 && count != 7'd0) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R1 unexpected read data", int'({rd_err, rd_data}), -1);
                end else begin
                    logic [10:0] exp_w;
                    exp_w = sbq.pop_front();
                    chk({rd_err, rd_data} == exp_w, "R1 data and tags", int'({rd_err, rd_data}), int'(exp_w));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; wr_err = '0;
        trig_sel = 2'd1; auto_rts_en = 1'b0; rts_start = 1'b0;
        rts_irq_en = 1'b0; rts_irq_ack = 1'b0; ovr_clr = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R10 reset state
        chk(count == 0, "R10 count", int'(count), 0);
        chk(rts_n == 1'b1, "R10 rts_n", int'(rts_n), 1);
        chk(!rx_irq && !rts_irq && !overrun, "R10 flags", int'({rx_irq, rts_irq, overrun}), 0);

        // R7 manual RTS
        rts_start = 1'b1; step();
        chk(rts_n == 1'b0, "R7 start high", int'(rts_n), 0);
        rts_start = 1'b0; step();
        chk(rts_n == 1'b1, "R7 start low", int'(rts_n), 1);

        // R8 auto enabled without start, then arming
        auto_rts_en = 1'b1; rts_irq_en = 1'b1; step();
        chk(rts_n == 1'b1, "R8 held off", int'(rts_n), 1);
        rts_start = 1'b1; step();
        chk(rts_n == 1'b0, "R8 armed on", int'(rts_n), 0);

        // trigger 16: off at 56, on at 8
        fill_to(16);
        chk(rts_n == 1'b0, "R5 low at trigger", int'(rts_n), 0);
        fill_to(55);
        chk(rts_n == 1'b0, "R5 low at 55", int'(rts_n), 0);
        chk(rts_irq == 1'b0, "R9 no irq yet", int'(rts_irq), 0);
        wr1();
        chk(rts_n == 1'b1, "R5 off at 56", int'(rts_n), 1);
        chk(rts_irq == 1'b1, "R9 irq on rise", int'(rts_irq), 1);
        rts_irq_ack = 1'b1; step(); rts_irq_ack = 1'b0;
        chk(rts_irq == 1'b0, "R9 ack clears", int'(rts_irq), 0);

        // keeps accepting until full, then overrun
        fill_to(DEPTH);
        chk(count == 7'd64, "R2 full", int'(count), 64);
        chk(overrun == 1'b0, "R3 no overrun yet", int'(overrun), 0);
        wr1();
        chk(overrun == 1'b1, "R3 overrun set", int'(overrun), 1);
        chk(count == 7'd64, "R3 dropped", int'(count), 64);
        rw1();
        chk(count == 7'd64, "R2 read+write at full", int'(count), 64);
        step();
        chk(overrun == 1'b1, "R3 sticky", int'(overrun), 1);
        ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
        chk(overrun == 1'b0, "R3 cleared", int'(overrun), 0);

        drain_to(9);
        chk(rts_n == 1'b1, "R6 still off at 9", int'(rts_n), 1);
        rd1();
        chk(rts_n == 1'b0, "R6 on at 8", int'(rts_n), 0);
        drain_to(0);

        // R11 read when empty
        rd1();
        chk(count == 0, "R11 empty read", int'(count), 0);
        wr1();
        rd1();
        chk(sbq.size() == 0, "R11 contents intact", sbq.size(), 0);

        // trigger 60: off at 60, on at 56, irq disabled
        trig_sel = 2'd3; rts_irq_en = 1'b0; step();
        fill_to(59);
        chk(rts_n == 1'b0, "R5 low at 59", int'(rts_n), 0);
        wr1();
        chk(rts_n == 1'b1, "R5 off at 60", int'(rts_n), 1);
        chk(rts_irq == 1'b0, "R9 disabled", int'(rts_irq), 0);
        drain_to(57);
        chk(rts_n == 1'b1, "R6 off at 57", int'(rts_n), 1);
        rd1();
        chk(rts_n == 1'b0, "R6 on at 56", int'(rts_n), 0);
        drain_to(0);

        // trigger 8: off at 16, on at 0
        trig_sel = 2'd0; step();
        fill_to(15);
        chk(rts_n == 1'b0, "R5 low at 15", int'(rts_n), 0);
        wr1();
        chk(rts_n == 1'b1, "R5 off at 16", int'(rts_n), 1);
        drain_to(1);
        chk(rts_n == 1'b1, "R6 off at 1", int'(rts_n), 1);
        rd1();
        chk(rts_n == 1'b0, "R6 on at 0", int'(rts_n), 0);

        repeat (3) step();
        finish_run();
    end

endmodule